// File: doc/BRIEF.md
# Directory-Coherent Cache Site Controller

This block is the controller that one processing site places between its processor and a directory-based coherence fabric. It keeps a small direct-mapped array of single-word lines. Each line has a tag, a data word and one of four coherence states: absent, shared-clean, exclusive-modified, or waiting. The waiting state means a request to the home directory is still in flight.

The processor side uses a valid/ready request channel and a one-cycle response pulse that carries the read data. The home side has one incoming and one outgoing message channel. Each message carries a type code, a full address and a data word. The channels are assumed to be lossless and to keep order between any pair of endpoints.

The controller fetches lines in shared or exclusive mode. It upgrades shared lines on a store, and it writes back a dirty victim before it reuses that slot. It also answers the home's invalidate, writeback and flush demands, and it keeps doing so while its own miss is outstanding.

Only one processor miss may be outstanding at a time. A shared line is dropped silently when it is replaced.

Top module: `coh_cache_node`

## Requirements
- R1: After synchronous reset every line is absent, `cpu_ready` is high, and no response or outgoing message is valid. The first access to any address therefore misses.
- R2: A load that misses sends a shared-request message for its address with zero data in the cycle after acceptance. When the matching shared-reply arrives, `rsp_valid` pulses one cycle later with the reply's data, and the line becomes shared.
- R3: A load that hits a shared or exclusive line, and a store that hits an exclusive line, each produce `rsp_valid` one cycle after acceptance and send no message. A store response returns the stored value, and the store updates the line.
- R4: A store to an absent line, or to a line held under another tag, sends an exclusive-request message. When the matching exclusive-reply arrives, the line becomes exclusive holding the store data, and the response returns that data.
- R5: A store that hits a shared line sends an exclusive-request (upgrade) instead of completing.
- R6: Every invalidate demand is answered one cycle later with an invalidate-ack for the same address and zero data, whether or not the line is present. A present shared or exclusive copy is dropped, so a later load misses.
- R7: An invalidate demand for the waiting line is acknowledged at once. The line stays waiting, `cpu_ready` stays low, and the line's own reply later completes the access.
- R8: A writeback demand for an exclusive line is answered with a writeback-reply carrying the current data. The line stays present as shared. A writeback demand for a line that is not exclusive gets no answer.
- R9: A flush demand for an exclusive line is answered with a flush-reply carrying the data, and the line becomes absent. A flush demand for a non-exclusive line gets no answer.
- R10: A miss whose slot holds an exclusive line under another tag first sends a flush-reply with the victim's address and data, one cycle after acceptance. The request for the new address follows in the next cycle. A shared victim is replaced with no message.
- R11: `cpu_ready` is low in any cycle where a home message is valid, and from the acceptance of a miss until its reply has been consumed. Home demands for other lines are still serviced while a miss waits.
- R12: Message codes are as follows. Shared-request 0, exclusive-request 1, writeback demand 2, invalidate demand 3, flush demand 4, writeback-reply 5, invalidate-ack 6, flush-reply 7, shared-reply 8, exclusive-reply 9. The line index is taken from the low `log2(LINES)` address bits and the tag from the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Controller can accept a processor request |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load data or stored value |
| home_in_valid | input | 1 | Incoming home message valid |
| home_in_type | input | 4 | Incoming message code |
| home_in_addr | input | ADDR_W | Incoming message address |
| home_in_data | input | DATA_W | Incoming message data |
| home_out_valid | output | 1 | Outgoing message valid |
| home_out_type | output | 4 | Outgoing message code |
| home_out_addr | output | ADDR_W | Outgoing message address |
| home_out_data | output | DATA_W | Outgoing message data |

## Verification
The bench builds the block with its defaults: 8-bit addresses, 16-bit data and four lines. With only four slots, two addresses such as 0x10 and 0x14 collide in slot 0 after a handful of accesses. That makes silent shared replacement and dirty-victim flushing easy to provoke. It also lets one slot sit waiting while another, unrelated slot is invalidated. The short tags make it cheap to send home demands to lines that are absent, held under a different tag, or in the waiting state.

// File: rtl/coh_node_pkg.sv
package coh_node_pkg;

    // Per-line coherence state
    typedef enum logic [1:0] {
        LS_NOTHING = 2'd0,
        LS_SH      = 2'd1,
        LS_EX      = 2'd2,
        LS_PEND    = 2'd3
    } line_st_t;

    // Message codes on both home channels
    typedef enum logic [3:0] {
        M_SH_REQ    = 4'd0,
        M_EX_REQ    = 4'd1,
        M_WB_REQ    = 4'd2,
        M_INV_REQ   = 4'd3,
        M_FLUSH_REQ = 4'd4,
        M_WB_REP    = 4'd5,
        M_INV_REP   = 4'd6,
        M_FLUSH_REP = 4'd7,
        M_SH_REP    = 4'd8,
        M_EX_REP    = 4'd9
    } msg_t;

    // Controller sequencing
    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_ISSUE = 2'd1,
        C_WAIT  = 2'd2
    } ctl_st_t;

    function automatic logic is_fill(msg_t m);
        return (m == M_SH_REP) || (m == M_EX_REP);
    endfunction

    function automatic msg_t req_for(logic wr);
        return wr ? M_EX_REQ : M_SH_REQ;
    endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_node_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_st_t          rd_st,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_t          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [LINES-1:0][1:0]        st_v;
    logic [LINES-1:0][TAG_W-1:0]  tag_v;
    logic [LINES-1:0][DATA_W-1:0] data_v;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [1:0]        st_r;
            logic [TAG_W-1:0]  tag_r;
            logic [DATA_W-1:0] data_r;

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_r   <= LS_NOTHING;
                    tag_r  <= '0;
                    data_r <= '0;
                end else if (we && (wr_idx == IDX_W'(g))) begin
                    st_r   <= wr_st;
                    tag_r  <= wr_tag;
                    data_r <= wr_data;
                end
            end

            assign st_v[g]   = st_r;
            assign tag_v[g]  = tag_r;
            assign data_v[g] = data_r;
        end
    endgenerate

    assign rd_st   = line_st_t'(st_v[rd_idx]);
    assign rd_tag  = tag_v[rd_idx];
    assign rd_data = data_v[rd_idx];

endmodule

// File: rtl/coh_home_resp.sv
module coh_home_resp
    import coh_node_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  msg_t              msg_type,
    input  logic [TAG_W-1:0]  msg_tag,
    input  line_st_t          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              reply_vld,
    output msg_t              reply_type,
    output logic [DATA_W-1:0] reply_data,
    output logic              upd,
    output line_st_t          upd_st
);
    logic tag_hit;
    assign tag_hit = (line_tag == msg_tag) && (line_st != LS_NOTHING);

    always_comb begin
        reply_vld  = 1'b0;
        reply_type = M_INV_REP;
        reply_data = '0;
        upd        = 1'b0;
        upd_st     = line_st;
        unique case (msg_type)
            M_INV_REQ: begin
                // always acknowledged; a waiting line keeps waiting
                reply_vld = 1'b1;
                if (tag_hit && (line_st != LS_PEND)) begin
                    upd    = 1'b1;
                    upd_st = LS_NOTHING;
                end
            end
            M_WB_REQ: begin
                if (tag_hit && (line_st == LS_EX)) begin
                    reply_vld  = 1'b1;
                    reply_type = M_WB_REP;
                    reply_data = line_data;
                    upd        = 1'b1;
                    upd_st     = LS_SH;
                end
            end
            M_FLUSH_REQ: begin
                if (tag_hit && (line_st == LS_EX)) begin
                    reply_vld  = 1'b1;
                    reply_type = M_FLUSH_REP;
                    reply_data = line_data;
                    upd        = 1'b1;
                    upd_st     = LS_NOTHING;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_cache_node.sv
module coh_cache_node
    import coh_node_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              home_in_valid,
    input  logic [3:0]        home_in_type,
    input  logic [ADDR_W-1:0] home_in_addr,
    input  logic [DATA_W-1:0] home_in_data,
    output logic              home_out_valid,
    output logic [3:0]        home_out_type,
    output logic [ADDR_W-1:0] home_out_addr,
    output logic [DATA_W-1:0] home_out_data
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    // address split
    logic [IDX_W-1:0] cpu_idx, in_idx, rd_idx;
    logic [TAG_W-1:0] cpu_tag, in_tag;
    msg_t             in_msg;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign in_idx  = home_in_addr[IDX_W-1:0];
    assign in_tag  = home_in_addr[ADDR_W-1:IDX_W];
    assign in_msg  = msg_t'(home_in_type);
    assign rd_idx  = home_in_valid ? in_idx : cpu_idx;

    // controller state and the outstanding miss
    ctl_st_t           ctl_q, ctl_n;
    logic [IDX_W-1:0]  p_idx;
    logic [TAG_W-1:0]  p_tag;
    logic              p_write;
    logic [DATA_W-1:0] p_wdata;
    logic              latch_miss;

    // line array ports
    line_st_t          rd_st, wr_st;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              we;
    logic [IDX_W-1:0]  wr_idx;

    coh_line_array #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_st(rd_st), .rd_tag(rd_tag), .rd_data(rd_data),
        .we(we), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    // home demand handling
    logic              hr_vld, hr_upd;
    msg_t              hr_type;
    logic [DATA_W-1:0] hr_data;
    line_st_t          hr_st;

    coh_home_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_resp (
        .msg_type(in_msg), .msg_tag(in_tag),
        .line_st(rd_st), .line_tag(rd_tag), .line_data(rd_data),
        .reply_vld(hr_vld), .reply_type(hr_type), .reply_data(hr_data),
        .upd(hr_upd), .upd_st(hr_st)
    );

    // registered outputs
    logic              out_v_n, rsp_v_n;
    msg_t              out_t_n;
    logic [ADDR_W-1:0] out_a_n;
    logic [DATA_W-1:0] out_d_n, rsp_d_n;

    logic fill_mine, fast_hit;
    assign fill_mine = (ctl_q == C_WAIT) && is_fill(in_msg)
                       && (in_idx == p_idx) && (in_tag == p_tag);
    assign fast_hit  = (rd_tag == cpu_tag)
                       && ((rd_st == LS_EX) || ((rd_st == LS_SH) && !cpu_write));
    assign cpu_ready = (ctl_q == C_IDLE) && !home_in_valid;

    always_comb begin
        we         = 1'b0;
        wr_idx     = rd_idx;
        wr_st      = rd_st;
        wr_tag     = rd_tag;
        wr_data    = rd_data;
        ctl_n      = ctl_q;
        latch_miss = 1'b0;
        out_v_n    = 1'b0;
        out_t_n    = M_SH_REQ;
        out_a_n    = '0;
        out_d_n    = '0;
        rsp_v_n    = 1'b0;
        rsp_d_n    = '0;
        if (home_in_valid) begin
            if (fill_mine) begin
                we      = 1'b1;
                wr_idx  = p_idx;
                wr_tag  = p_tag;
                wr_st   = (in_msg == M_SH_REP) ? LS_SH : LS_EX;
                wr_data = p_write ? p_wdata : home_in_data;
                rsp_v_n = 1'b1;
                rsp_d_n = p_write ? p_wdata : home_in_data;
                ctl_n   = C_IDLE;
            end else begin
                we      = hr_upd;
                wr_st   = hr_st;
                out_v_n = hr_vld;
                out_t_n = hr_type;
                out_a_n = home_in_addr;
                out_d_n = hr_data;
            end
        end else begin
            unique case (ctl_q)
                C_IDLE: begin
                    if (cpu_valid) begin
                        if (fast_hit) begin
                            rsp_v_n = 1'b1;
                            rsp_d_n = cpu_write ? cpu_wdata : rd_data;
                            if (cpu_write) begin
                                we      = 1'b1;
                                wr_data = cpu_wdata;
                            end
                        end else begin
                            latch_miss = 1'b1;
                            we         = 1'b1;
                            out_v_n    = 1'b1;
                            if (rd_st == LS_EX) begin
                                // dirty victim goes back first
                                out_t_n = M_FLUSH_REP;
                                out_a_n = {rd_tag, cpu_idx};
                                out_d_n = rd_data;
                                wr_st   = LS_NOTHING;
                                ctl_n   = C_ISSUE;
                            end else begin
                                out_t_n = req_for(cpu_write);
                                out_a_n = cpu_addr;
                                wr_st   = LS_PEND;
                                wr_tag  = cpu_tag;
                                ctl_n   = C_WAIT;
                            end
                        end
                    end
                end
                C_ISSUE: begin
                    we      = 1'b1;
                    wr_idx  = p_idx;
                    wr_st   = LS_PEND;
                    wr_tag  = p_tag;
                    wr_data = '0;
                    out_v_n = 1'b1;
                    out_t_n = req_for(p_write);
                    out_a_n = {p_tag, p_idx};
                    ctl_n   = C_WAIT;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q          <= C_IDLE;
            p_idx          <= '0;
            p_tag          <= '0;
            p_write        <= 1'b0;
            p_wdata        <= '0;
            home_out_valid <= 1'b0;
            home_out_type  <= '0;
            home_out_addr  <= '0;
            home_out_data  <= '0;
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
        end else begin
            ctl_q          <= ctl_n;
            home_out_valid <= out_v_n;
            home_out_type  <= out_t_n;
            home_out_addr  <= out_a_n;
            home_out_data  <= out_d_n;
            rsp_valid      <= rsp_v_n;
            rsp_rdata      <= rsp_d_n;
            if (latch_miss) begin
                p_idx   <= cpu_idx;
                p_tag   <= cpu_tag;
                p_write <= cpu_write;
                p_wdata <= cpu_wdata;
            end
        end
    end

endmodule

// File: rtl/coh_cache_node_chk.sv
module coh_cache_node_chk
    import coh_node_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              rsp_valid,
    input logic              home_in_valid,
    input logic [3:0]        home_in_type,
    input logic [ADDR_W-1:0] home_in_addr,
    input logic              home_out_valid,
    input logic [3:0]        home_out_type,
    input logic [ADDR_W-1:0] home_out_addr
);
    // an accepted access either completes or talks to the home next cycle
    assert_accept_progress_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready) |=> (rsp_valid || home_out_valid));

    // the processor port is closed whenever a home message is presented
    assert_home_blocks_cpu_R11: assert property (@(posedge clk) disable iff (rst)
        home_in_valid |-> !cpu_ready);

    // every invalidate demand is acknowledged for the same address
    assert_inv_acked_R6: assert property (@(posedge clk) disable iff (rst)
        (home_in_valid && (home_in_type == 4'(M_INV_REQ)))
        |=> (home_out_valid && (home_out_type == 4'(M_INV_REP))
             && (home_out_addr == $past(home_in_addr))));

    // once a request has gone out, the port stays closed
    assert_req_closes_port_R11: assert property (@(posedge clk) disable iff (rst)
        (home_out_valid && ((home_out_type == 4'(M_SH_REQ)) || (home_out_type == 4'(M_EX_REQ))))
        |-> !cpu_ready);

    // a completion without an accepted access must come from a fill reply
    assert_rsp_from_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(cpu_valid && cpu_ready))
        |-> $past(home_in_valid && ((home_in_type == 4'(M_SH_REP)) || (home_in_type == 4'(M_EX_REP)))));

endmodule

bind coh_cache_node coh_cache_node_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .rsp_valid(rsp_valid), .home_in_valid(home_in_valid), .home_in_type(home_in_type),
    .home_in_addr(home_in_addr), .home_out_valid(home_out_valid),
    .home_out_type(home_out_type), .home_out_addr(home_out_addr)
);

// File: tb/tb_coh_cache_node.sv
module tb_coh_cache_node;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_valid, cpu_write, cpu_ready;
    logic [7:0]  cpu_addr;
    logic [15:0] cpu_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        home_in_valid;
    logic [3:0]  home_in_type;
    logic [7:0]  home_in_addr;
    logic [15:0] home_in_data;
    logic        home_out_valid;
    logic [3:0]  home_out_type;
    logic [7:0]  home_out_addr;
    logic [15:0] home_out_data;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    coh_cache_node #(.ADDR_W(8), .DATA_W(16), .LINES(4)) dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .home_in_valid(home_in_valid), .home_in_type(home_in_type),
        .home_in_addr(home_in_addr), .home_in_data(home_in_data),
        .home_out_valid(home_out_valid), .home_out_type(home_out_type),
        .home_out_addr(home_out_addr), .home_out_data(home_out_data)
    );

    typedef struct packed {
        logic        cv;
        logic        cw;
        logic [7:0]  ca;
        logic [15:0] cd;
        logic        hv;
        logic [3:0]  ht;
        logic [7:0]  ha;
        logic [15:0] hd;
        logic        rdy;
        logic        rv;
        logic [15:0] rd;
        logic        ov;
        logic [3:0]  ot;
        logic [7:0]  oa;
        logic [15:0] od;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,8'h10,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b0,16'h0000, 1'b1,4'd0,8'h10,16'h0000, 8'd2},  // R2 R12 load miss
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd8,8'h10,16'hAAAA, 1'b0,1'b1,16'hAAAA, 1'b0,4'd0,8'h00,16'h0000, 8'd2},  // R2 fill shared
        '{1'b1,1'b0,8'h10,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b1,16'hAAAA, 1'b0,4'd0,8'h00,16'h0000, 8'd3},  // R3 load hit Sh
        '{1'b1,1'b1,8'h10,16'h1111, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b0,16'h0000, 1'b1,4'd1,8'h10,16'h0000, 8'd5},  // R5 upgrade
        '{1'b0,1'b0,8'h00,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 8'd11}, // R11 waiting
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd9,8'h10,16'hAAAA, 1'b0,1'b1,16'h1111, 1'b0,4'd0,8'h00,16'h0000, 8'd4},  // R4 fill Ex
        '{1'b1,1'b0,8'h10,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b1,16'h1111, 1'b0,4'd0,8'h00,16'h0000, 8'd3},  // R3 load hit Ex
        '{1'b1,1'b1,8'h10,16'h2222, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b1,16'h2222, 1'b0,4'd0,8'h00,16'h0000, 8'd3},  // R3 store hit Ex
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd2,8'h10,16'h0000, 1'b0,1'b0,16'h0000, 1'b1,4'd5,8'h10,16'h2222, 8'd8},  // R8 writeback
        '{1'b1,1'b0,8'h10,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b1,16'h2222, 1'b0,4'd0,8'h00,16'h0000, 8'd8},  // R8 still shared
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd2,8'h10,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 8'd8},  // R8 no reply
        '{1'b1,1'b1,8'h14,16'h3333, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b0,16'h0000, 1'b1,4'd1,8'h14,16'h0000, 8'd10}, // R10 silent Sh evict
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd3,8'h14,16'h0000, 1'b0,1'b0,16'h0000, 1'b1,4'd6,8'h14,16'h0000, 8'd7},  // R7 inv on pending
        '{1'b0,1'b0,8'h00,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 8'd7},  // R7 still waiting
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd9,8'h14,16'h0000, 1'b0,1'b1,16'h3333, 1'b0,4'd0,8'h00,16'h0000, 8'd7},  // R7 own reply
        '{1'b1,1'b0,8'h10,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b0,16'h0000, 1'b1,4'd7,8'h14,16'h3333, 8'd10}, // R10 dirty victim
        '{1'b0,1'b0,8'h00,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b0,1'b0,16'h0000, 1'b1,4'd0,8'h10,16'h0000, 8'd10}, // R10 then request
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd8,8'h10,16'h4444, 1'b0,1'b1,16'h4444, 1'b0,4'd0,8'h00,16'h0000, 8'd2},  // R2 fill
        '{1'b1,1'b1,8'h21,16'h5555, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b0,16'h0000, 1'b1,4'd1,8'h21,16'h0000, 8'd4},  // R4 store miss
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd3,8'h10,16'h0000, 1'b0,1'b0,16'h0000, 1'b1,4'd6,8'h10,16'h0000, 8'd11}, // R11 other line served
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd9,8'h21,16'h0000, 1'b0,1'b1,16'h5555, 1'b0,4'd0,8'h00,16'h0000, 8'd4},  // R4 fill Ex
        '{1'b1,1'b0,8'h10,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b0,16'h0000, 1'b1,4'd0,8'h10,16'h0000, 8'd6},  // R6 copy dropped
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd8,8'h10,16'h6666, 1'b0,1'b1,16'h6666, 1'b0,4'd0,8'h00,16'h0000, 8'd6},  // R6 refill
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd4,8'h21,16'h0000, 1'b0,1'b0,16'h0000, 1'b1,4'd7,8'h21,16'h5555, 8'd9},  // R9 flush Ex
        '{1'b1,1'b0,8'h21,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 1'b1,1'b0,16'h0000, 1'b1,4'd0,8'h21,16'h0000, 8'd9},  // R9 line gone
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd8,8'h21,16'h7777, 1'b0,1'b1,16'h7777, 1'b0,4'd0,8'h00,16'h0000, 8'd9},  // R9 refill
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd3,8'h33,16'h0000, 1'b0,1'b0,16'h0000, 1'b1,4'd6,8'h33,16'h0000, 8'd6},  // R6 absent line
        '{1'b0,1'b0,8'h00,16'h0000, 1'b1,4'd4,8'h10,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,4'd0,8'h00,16'h0000, 8'd9}   // R9 flush on Sh
    };

    task automatic chk(input logic ok, input int r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic logic [45:0] observed();
        return {rsp_valid, rsp_valid ? rsp_rdata : 16'h0,
                home_out_valid,
                home_out_valid ? {home_out_type, home_out_addr, home_out_data} : 28'h0};
    endfunction

    task automatic drive(input logic cv, input logic cw, input logic [7:0] ca, input logic [15:0] cd,
                         input logic hv, input logic [3:0] ht, input logic [7:0] ha, input logic [15:0] hd);
        cpu_valid = cv; cpu_write = cw; cpu_addr = ca; cpu_wdata = cd;
        home_in_valid = hv; home_in_type = ht; home_in_addr = ha; home_in_data = hd;
    endtask

    task automatic step_check(input int r, input string what, input logic rdy,
                              input logic [45:0] exp);
        #1;
        chk(cpu_ready == rdy, r, {what, " ready"}, 64'(cpu_ready), 64'(rdy));
        @(posedge clk); #2;
        chk(observed() == exp, r, {what, " outputs"}, 64'(observed()), 64'(exp));
    endtask

    initial begin : watchdog
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 8'h00, 16'h0, 0, 4'd0, 8'h00, 16'h0);
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #1;
        // R1 reset state
        chk(cpu_ready == 1'b1, 1, "reset ready", 64'(cpu_ready), 64'd1);
        chk(rsp_valid == 1'b0 && home_out_valid == 1'b0, 1, "reset outputs",
            64'({rsp_valid, home_out_valid}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            drive(v.cv, v.cw, v.ca, v.cd, v.hv, v.ht, v.ha, v.hd);
            step_check(int'(v.req), $sformatf("vec%0d", i), v.rdy,
                       {v.rv, v.rd, v.ov, v.ot, v.oa, v.od});
        end

        // R11: a processor request is held off while a home message is valid
        drive(1, 0, 8'h22, 16'h0, 1, 4'd3, 8'h22, 16'h0);
        step_check(11, "cpu blocked by home", 1'b0, {1'b0, 16'h0, 1'b1, 4'd6, 8'h22, 16'h0});
        drive(1, 0, 8'h22, 16'h0, 0, 4'd0, 8'h00, 16'h0);
        step_check(11, "cpu after home", 1'b1, {1'b0, 16'h0, 1'b1, 4'd0, 8'h22, 16'h0});
        drive(0, 0, 8'h00, 16'h0, 1, 4'd8, 8'h22, 16'hBEEF);
        step_check(2, "late fill", 1'b0, {1'b1, 16'hBEEF, 1'b0, 28'h0});

        // R1: reset clears lines that were shared
        drive(0, 0, 8'h00, 16'h0, 0, 4'd0, 8'h00, 16'h0);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        #1;
        chk(cpu_ready == 1'b1 && rsp_valid == 1'b0 && home_out_valid == 1'b0, 1, "re-reset idle",
            64'({cpu_ready, rsp_valid, home_out_valid}), 64'b100);
        drive(1, 0, 8'h22, 16'h0, 0, 4'd0, 8'h00, 16'h0);
        step_check(1, "miss after reset", 1'b1, {1'b0, 16'h0, 1'b1, 4'd0, 8'h22, 16'h0});
        drive(0, 0, 8'h00, 16'h0, 0, 4'd0, 8'h00, 16'h0);
        @(posedge clk); #2;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule